// File: doc/BRIEF.md
# Dual-Clock Timer with Buffered Register Writes

This block is an 8-bit counter that runs on a slow timer clock and is programmed from a faster bus clock. The bus writes three settings: the count, the compare value and the mode. Each setting has its own holding stage. A bus write lands in the holding stage and takes effect inside the timer domain on the second rising timer edge that follows it. While a setting is in flight, its busy bit is set. Software polls that bit before it writes the same setting again.

The timer has two count styles. In free-run mode it wraps from 255 to 0 and raises an overflow event. In clear-on-match mode the counter returns to zero on the tick that leaves the compare value. It advances on a prescaled tick: stopped, every clock, every 8 clocks or every 64 clocks. Compare and overflow events travel to the bus side as toggles. There they become sticky flags, and software clears each flag by writing a one to it.

A separate source bit picks the timer clock: the external slow clock or the bus clock itself. Changing that bit cancels every transfer still in flight. The bus clock must run more than four times faster than the timer clock.

Top module: `dual_clk_tmr`

## Requirements
- R1: The count (select 0), compare (select 1) and mode (select 2) settings are buffered separately. Writes on consecutive bus cycles to count and compare are both accepted, and `busy` reads 3'b011 (bit 0 count, bit 1 compare, bit 2 mode).
- R2: A setting accepted on a bus edge is still absent from the timer domain after the first following timer rising edge. It is in effect after the second.
- R3: A busy bit is set on the bus cycle after its write is accepted. It returns to 0 within 4 bus cycles after the timer edge that applied the value.
- R4: No compare event is raised on a timer edge that applies a pending count or compare write, even when the counter equals the old compare value on that tick.
- R5: In clear-on-match mode (mode bit 2 = 1), the counter steps through cmp-1, cmp, 0, 1, and the compare flag rises as the counter leaves cmp.
- R6: Mode bits [1:0] select the prescale: 0 stopped, 1 every timer clock, 2 every 8 clocks, 3 every 64 clocks. With code 2, each count value lasts exactly 8 timer clocks.
- R7: A write to a setting whose busy bit is set is ignored, and the earlier pending value is the one applied.
- R8: `cmp_flag` and `ovf_flag` are set within 4 bus cycles of their timer event. They stay set until a one is written on `flag_clr` (bit 0 compare, bit 1 overflow), which clears them on the next bus edge.
- R9: Writing select 3 with data bit 0 different from the current source (1 = external clock, 0 = bus clock) cancels every pending transfer. All busy bits are clear on the next bus cycle, and the cancelled value never reaches the counter.
- R10: In free-run mode (mode bit 2 = 0), the counter wraps from 255 to 0 and the overflow flag is set.
- R11: After reset, busy is 0, both flags are 0, the counter is 0, the prescale is stopped and the external clock is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| ext_clk | input | 1 | Slow external timer clock |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Target: 0 count, 1 compare, 2 mode, 3 clock source |
| wr_data | input | 8 | Write data |
| flag_clr | input | 2 | Write-one-to-clear: bit 0 compare, bit 1 overflow |
| busy | output | 3 | Transfer pending per setting |
| cmp_flag | output | 1 | Sticky compare flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| cnt_mon | output | 8 | Counter value, timer domain |

## Verification
A setting takes effect on the second timer rising edge after the bus edge that accepts it. Its busy bit drops on the third bus edge after that timer edge. A flag rises on the third bus edge after its timer event. The bench drives its own timer clock, so it waits on timer edges and samples one time unit after each edge. It gives the bus-side results six bus cycles, which is past their due cycle and still well inside one timer period. Writes start just after a timer edge, so every write lands early in a timer period and its transfer edges fall at known points.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [1:0] SEL_CNT = 2'd0;
  localparam logic [1:0] SEL_CMP = 2'd1;
  localparam logic [1:0] SEL_CTL = 2'd2;
  localparam logic [1:0] SEL_SRC = 2'd3;
  localparam int CTL_W = 3;

  typedef enum logic [1:0] {
    PS_STOP  = 2'd0,
    PS_DIV1  = 2'd1,
    PS_DIV8  = 2'd2,
    PS_DIV64 = 2'd3
  } psel_e;

  typedef struct packed {
    logic  ctc;
    psel_e psel;
  } ctl_t;
endpackage

// File: rtl/tmr_wr_bridge.sv
module tmr_wr_bridge #(
  parameter int W = 8
) (
  input  logic         bus_clk,
  input  logic         bus_rst,
  input  logic         wr_stb,
  input  logic [W-1:0] wr_data,
  input  logic         abort,
  output logic         busy,
  input  logic         t_clk,
  input  logic         t_rst,
  output logic         t_apply,
  output logic [W-1:0] t_data
);
  logic [W-1:0] hold;
  logic req, as1, as2, as3;
  logic rs1, ack;

  // bus side: capture, toggle request, watch the returned acknowledge
  always_ff @(posedge bus_clk) begin
    if (bus_rst) begin
      hold <= '0;
      req  <= 1'b0;
      busy <= 1'b0;
      as1  <= 1'b0;
      as2  <= 1'b0;
      as3  <= 1'b0;
    end else begin
      as1 <= ack;
      as2 <= as1;
      as3 <= as2;
      if (abort) begin
        if (busy) req <= ~req;
        busy <= 1'b0;
      end else if (wr_stb && !busy) begin
        hold <= wr_data;
        req  <= ~req;
        busy <= 1'b1;
      end else if (as2 != as3) begin
        busy <= 1'b0;
      end
    end
  end

  // timer side: one capture stage, apply on the next edge
  always_ff @(posedge t_clk) begin
    if (t_rst) begin
      rs1 <= 1'b0;
      ack <= 1'b0;
    end else begin
      rs1 <= req;
      if (t_apply) ack <= rs1;
    end
  end

  assign t_apply = rs1 ^ ack;
  assign t_data  = hold;

  // R3
  busy_rise_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
    $rose(busy) |-> $past(wr_stb));
  // R7
  busy_hold_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
    (busy && wr_stb && !abort) |=> $stable(hold));
  // R9
  abort_clr_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
    abort |=> !busy);
endmodule

// File: rtl/tmr_flag_xfer.sv
module tmr_flag_xfer (
  input  logic bus_clk,
  input  logic bus_rst,
  input  logic evt_tog,
  input  logic clr,
  output logic flag
);
  logic s1, s2, s3;
  logic seen;

  assign seen = s2 ^ s3;

  always_ff @(posedge bus_clk) begin
    if (bus_rst) begin
      s1   <= 1'b0;
      s2   <= 1'b0;
      s3   <= 1'b0;
      flag <= 1'b0;
    end else begin
      s1 <= evt_tog;
      s2 <= s1;
      s3 <= s2;
      if (seen)     flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end

  // R8
  flag_clr_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
    (clr && !seen) |=> !flag);
  // R8
  flag_src_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
    $rose(flag) |-> $past(s2 != s3));
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CW = 8,
  parameter int PW = 6
) (
  input  logic             t_clk,
  input  logic             t_rst,
  input  logic             ap_cnt,
  input  logic             ap_cmp,
  input  logic             ap_ctl,
  input  logic [CW-1:0]    d_cnt,
  input  logic [CW-1:0]    d_cmp,
  input  logic [CTL_W-1:0] d_ctl,
  output logic [CW-1:0]    cnt,
  output logic             cmp_tog,
  output logic             ovf_tog
);
  localparam logic [PW-1:0] LIM_8  = PW'(7);
  localparam logic [PW-1:0] LIM_64 = '1;

  ctl_t          ctl;
  logic [CW-1:0] cmp;
  logic [PW-1:0] pre, lim;
  logic          tick, hit, hold_off;

  always_comb begin
    unique case (ctl.psel)
      PS_DIV8:  lim = LIM_8;
      PS_DIV64: lim = LIM_64;
      default:  lim = '0;
    endcase
  end

  assign tick     = (ctl.psel != PS_STOP) && (pre >= lim);
  assign hold_off = ap_cnt | ap_cmp;
  assign hit      = tick && (cnt == cmp) && !hold_off;

  always_ff @(posedge t_clk) begin
    if (t_rst) begin
      ctl     <= '0;
      cmp     <= '0;
      cnt     <= '0;
      pre     <= '0;
      cmp_tog <= 1'b0;
      ovf_tog <= 1'b0;
    end else begin
      if (ap_ctl) ctl <= ctl_t'(d_ctl);
      if (ap_cmp) cmp <= d_cmp;
      pre <= (tick || ctl.psel == PS_STOP) ? '0 : pre + 1'b1;
      if (ap_cnt)                cnt <= d_cnt;
      else if (hit && ctl.ctc)   cnt <= '0;
      else if (tick)             cnt <= cnt + 1'b1;
      if (hit) cmp_tog <= ~cmp_tog;
      if (tick && !ctl.ctc && !ap_cnt && (cnt == '1)) ovf_tog <= ~ovf_tog;
    end
  end

  // R5
  ctc_wrap_chk: assert property (@(posedge t_clk) disable iff (t_rst)
    (hit && ctl.ctc) |=> (cnt == '0));
  // R4
  pend_mute_chk: assert property (@(posedge t_clk) disable iff (t_rst)
    (ap_cnt || ap_cmp) |=> $stable(cmp_tog));
  // R10
  ovf_src_chk: assert property (@(posedge t_clk) disable iff (t_rst)
    (ovf_tog != $past(ovf_tog)) |-> ($past(cnt) == '1));
endmodule

// File: rtl/dual_clk_tmr.sv
module dual_clk_tmr
  import tmr_pkg::*;
#(
  parameter int DW = 8,
  parameter int PW = 6
) (
  input  logic          bus_clk,
  input  logic          bus_rst,
  input  logic          ext_clk,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    flag_clr,
  output logic [2:0]    busy,
  output logic          cmp_flag,
  output logic          ovf_flag,
  output logic [DW-1:0] cnt_mon
);
  localparam int NDAT = 2;

  logic src_ext;
  logic abort;
  logic tclk;
  logic trs1 = 1'b1;
  logic trs2 = 1'b1;
  logic [NDAT-1:0] t_ap;
  logic [DW-1:0]   t_dat [NDAT];
  logic             ap_ctl;
  logic [CTL_W-1:0] d_ctl;
  logic cmp_tog, ovf_tog;

  // clock source select, written directly on the bus side
  always_ff @(posedge bus_clk) begin
    if (bus_rst) src_ext <= 1'b1;
    else if (wr_en && wr_sel == SEL_SRC) src_ext <= wr_data[0];
  end

  assign abort = wr_en && (wr_sel == SEL_SRC) && (wr_data[0] != src_ext);
  assign tclk  = src_ext ? ext_clk : bus_clk;

  always_ff @(posedge tclk) begin
    trs1 <= bus_rst;
    trs2 <= trs1;
  end

  for (genvar g = 0; g < NDAT; g++) begin : g_dat
    tmr_wr_bridge #(.W(DW)) u_br (
      .bus_clk (bus_clk),
      .bus_rst (bus_rst),
      .wr_stb  (wr_en && (wr_sel == 2'(g))),
      .wr_data (wr_data),
      .abort   (abort),
      .busy    (busy[g]),
      .t_clk   (tclk),
      .t_rst   (trs2),
      .t_apply (t_ap[g]),
      .t_data  (t_dat[g])
    );
  end

  tmr_wr_bridge #(.W(CTL_W)) u_br_ctl (
    .bus_clk (bus_clk),
    .bus_rst (bus_rst),
    .wr_stb  (wr_en && (wr_sel == SEL_CTL)),
    .wr_data (wr_data[CTL_W-1:0]),
    .abort   (abort),
    .busy    (busy[2]),
    .t_clk   (tclk),
    .t_rst   (trs2),
    .t_apply (ap_ctl),
    .t_data  (d_ctl)
  );

  tmr_core #(.CW(DW), .PW(PW)) u_core (
    .t_clk   (tclk),
    .t_rst   (trs2),
    .ap_cnt  (t_ap[0]),
    .ap_cmp  (t_ap[1]),
    .ap_ctl  (ap_ctl),
    .d_cnt   (t_dat[0]),
    .d_cmp   (t_dat[1]),
    .d_ctl   (d_ctl),
    .cnt     (cnt_mon),
    .cmp_tog (cmp_tog),
    .ovf_tog (ovf_tog)
  );

  tmr_flag_xfer u_cmp_fl (
    .bus_clk (bus_clk),
    .bus_rst (bus_rst),
    .evt_tog (cmp_tog),
    .clr     (flag_clr[0]),
    .flag    (cmp_flag)
  );

  tmr_flag_xfer u_ovf_fl (
    .bus_clk (bus_clk),
    .bus_rst (bus_rst),
    .evt_tog (ovf_tog),
    .clr     (flag_clr[1]),
    .flag    (ovf_flag)
  );

  // R9
  src_abort_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
    abort |=> (busy == '0));
endmodule

// File: tb/dual_clk_tmr_tb.sv
module dual_clk_tmr_tb;
  import tmr_pkg::*;

  logic       bclk = 1'b0;
  logic       eclk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [1:0] flag_clr = 2'd0;
  logic [2:0] busy;
  logic       cmp_flag, ovf_flag;
  logic [7:0] cnt_mon;

  always #2 bclk = ~bclk;
  always #20 eclk = ~eclk;

  dual_clk_tmr u_dut (
    .bus_clk(bclk), .bus_rst(rst), .ext_clk(eclk), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .flag_clr(flag_clr),
    .busy(busy), .cmp_flag(cmp_flag), .ovf_flag(ovf_flag), .cnt_mon(cnt_mon)
  );

  typedef struct {
    string       rid;
    logic [31:0] exp;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int errors = 0;

  task automatic push(input string rid, input logic [31:0] exp);
    sb.push_back('{rid, exp});
  endtask

  task automatic monitor(input logic [31:0] act);
    exp_t e;
    e = sb.pop_front();
    checks++;
    if (act !== e.exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", e.rid, act, e.exp);
    end
  endtask

  task automatic chk(input string rid, input logic [31:0] act, input logic [31:0] exp);
    push(rid, exp);
    monitor(act);
  endtask

  task automatic tick_e();
    @(posedge eclk);
    #1;
  endtask

  task automatic bwait(input int n);
    repeat (n) @(negedge bclk);
  endtask

  task automatic bus_wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge bclk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge bclk);
    wr_en = 1'b0;
  endtask

  task automatic clr_flags(input logic [1:0] m);
    @(negedge bclk);
    flag_clr = m;
    @(negedge bclk);
    flag_clr = 2'b00;
  endtask

  task automatic settle();
    tick_e(); tick_e(); bwait(6);
  endtask

  initial begin
    repeat (150000) @(posedge bclk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] prev, saved;
    int n;
    bwait(50);
    rst = 1'b0;
    repeat (4) tick_e();

    // R11 reset state
    chk("R11 busy", busy, 3'b000);
    chk("R11 flags", {cmp_flag, ovf_flag}, 2'b00);
    chk("R11 count", cnt_mon, 8'd0);
    repeat (3) tick_e();
    chk("R11 stopped", cnt_mon, 8'd0);

    // R2 / R3 transfer timing
    tick_e();
    bus_wr(SEL_CNT, 8'h2A);
    chk("R3 busy set", busy, 3'b001);
    tick_e();
    chk("R2 first edge", cnt_mon, 8'd0);
    tick_e();
    chk("R2 second edge", cnt_mon, 8'h2A);
    bwait(6);
    chk("R3 busy clear", busy, 3'b000);

    // R1 / R7 independent holding, ignored rewrite
    tick_e();
    bus_wr(SEL_CNT, 8'd7);
    bus_wr(SEL_CMP, 8'd9);
    chk("R1 both busy", busy, 3'b011);
    bus_wr(SEL_CNT, 8'h55);
    settle();
    chk("R7 first value kept", cnt_mon, 8'd7);
    chk("R3 all idle", busy, 3'b000);

    // R5 clear-on-match sequence
    tick_e();
    bus_wr(SEL_CNT, 8'd3);
    bus_wr(SEL_CMP, 8'd5);
    settle();
    tick_e();
    bus_wr(SEL_CTL, 8'h05);
    tick_e(); tick_e();
    chk("R5 start", cnt_mon, 8'd3);
    tick_e(); chk("R5 top-1", cnt_mon, 8'd4);
    tick_e(); chk("R5 top", cnt_mon, 8'd5);
    chk("R5 no flag yet", cmp_flag, 1'b0);
    tick_e(); chk("R5 bottom", cnt_mon, 8'd0);
    bwait(6);
    chk("R8 cmp flag set", cmp_flag, 1'b1);
    tick_e(); chk("R5 bottom+1", cnt_mon, 8'd1);
    clr_flags(2'b01);
    chk("R8 cmp flag cleared", cmp_flag, 1'b0);
    bus_wr(SEL_CTL, 8'h00);
    repeat (3) tick_e();
    chk("R6 stopped", cnt_mon, 8'd3);

    // R6 prescale by 8
    bus_wr(SEL_CMP, 8'd200);
    settle();
    tick_e();
    bus_wr(SEL_CTL, 8'h02);
    prev = cnt_mon;
    n = 0;
    while (cnt_mon == prev && n < 40) begin tick_e(); n++; end
    for (int k = 0; k < 2; k++) begin
      prev = cnt_mon;
      n = 0;
      while (cnt_mon == prev && n < 40) begin tick_e(); n++; end
      chk("R6 hold length", n, 8);
    end
    bus_wr(SEL_CTL, 8'h00);
    settle();

    // R10 overflow in free-run mode
    tick_e();
    bus_wr(SEL_CNT, 8'd254);
    settle();
    clr_flags(2'b11);
    tick_e();
    bus_wr(SEL_CTL, 8'h01);
    tick_e(); tick_e();
    chk("R10 start", cnt_mon, 8'd254);
    tick_e(); chk("R10 max", cnt_mon, 8'd255);
    chk("R10 no flag yet", ovf_flag, 1'b0);
    tick_e(); chk("R10 wrap", cnt_mon, 8'd0);
    bwait(6);
    chk("R10 ovf flag", ovf_flag, 1'b1);

    // R4 match muted on the applying edge
    clr_flags(2'b11);
    n = 0;
    while (cnt_mon != 8'd199 && n < 300) begin tick_e(); n++; end
    bus_wr(SEL_CMP, 8'd10);
    tick_e(); chk("R4 at old compare", cnt_mon, 8'd200);
    tick_e(); chk("R4 moved on", cnt_mon, 8'd201);
    bwait(6);
    chk("R4 no compare flag", cmp_flag, 1'b0);
    bus_wr(SEL_CTL, 8'h00);
    settle();

    // R9 source change cancels pending transfers
    tick_e();
    saved = cnt_mon;
    bus_wr(SEL_CNT, 8'h11);
    chk("R9 pending", busy, 3'b001);
    bus_wr(SEL_SRC, 8'h00);
    chk("R9 busy cleared", busy, 3'b000);
    bwait(20);
    chk("R9 value dropped", cnt_mon, saved);
    bus_wr(SEL_SRC, 8'h01);
    bwait(4);
    tick_e(); tick_e();
    chk("R9 still dropped", cnt_mon, saved);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule